// File: doc/BRIEF.md
# Speculative Load Buffer with Address Generation

This block holds a small pool of in-flight loads for an out-of-order core. Each accepted load moves through a fixed sequence of phases. First it computes its effective address as a base register value plus a sign-extended offset. Next it issues a one-cycle memory read. Last it places the returned value on the common result bus, tagged with the load's reorder-buffer slot. A load whose base register is still being produced parks in its entry. It watches the result bus for the producer's tag and picks up the value when that tag appears.

Reads are issued speculatively. Nothing in the buffer waits for older branches to resolve, so a load reads memory as soon as its address is known. When a misprediction is detected, a flush input empties the whole buffer. The flush also throws away any read data that comes back for a load it removed. Only one read leaves the buffer per cycle. When several entries hold an address at the same time, the one accepted earliest goes first.

Top module: `load_buffer`

## Requirements
- R1: After reset every entry is free: `iss_ready` is 1, and `mrd_valid` and `cdb_valid` are 0.
- R2: A load offered with `iss_valid` while `iss_ready` is 1 takes the lowest-numbered free entry, and that entry number is the `mrd_id` of its read. `iss_ready` is 0 while all entries are occupied or `flush` is high. A load offered then is dropped and never produces a read.
- R3: A load accepted in cycle N with `iss_base_rdy`=1 drives its read no earlier than cycle N+2, the cycle after address generation. The read's `mrd_addr` is `iss_base` plus `iss_off` sign-extended from bit OFFW-1, modulo 2^XLEN.
- R4: A load accepted with `iss_base_rdy`=0 waits for a cycle M at or after its acceptance in which `rb_valid`=1 and `rb_tag` equals its `iss_base_tag`. It then uses `rb_value` of cycle M as its base, and its read is eligible from cycle M+2.
- R5: At most one read is requested per cycle. Among the entries whose address is ready, the one accepted earliest wins. A younger ready load reads before an older load that is still waiting for its base.
- R6: A response in cycle K (`mresp_valid`=1, `mresp_id` equal to an entry with a read outstanding) produces `cdb_valid`=1 in cycle K. It carries that load's reorder tag on `cdb_tag` and `mresp_data` on `cdb_value`, and the entry is free from cycle K+1. A response naming an entry with no outstanding read produces no broadcast.
- R7: In a cycle with `flush`=1 there is no read request and no broadcast, even if a response arrives. No load is accepted, and every entry is free from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard every entry and any returning data |
| iss_valid | input | 1 | A load is offered this cycle |
| iss_rob | input | TAGW | Reorder tag of the offered load |
| iss_base | input | XLEN | Base register value (valid when iss_base_rdy) |
| iss_base_rdy | input | 1 | Base value is available at issue |
| iss_base_tag | input | TAGW | Producer tag of the base when not ready |
| iss_off | input | OFFW | Signed address offset |
| iss_ready | output | 1 | A free entry can accept a load this cycle |
| rb_valid | input | 1 | Result bus carries a value |
| rb_tag | input | TAGW | Producer tag on the result bus |
| rb_value | input | XLEN | Value on the result bus |
| mrd_valid | output | 1 | Memory read request |
| mrd_id | output | IDW | Entry number of the request |
| mrd_addr | output | XLEN | Effective address of the request |
| mresp_valid | input | 1 | Memory read data returned |
| mresp_id | input | IDW | Entry number the data belongs to |
| mresp_data | input | XLEN | Returned data |
| cdb_valid | output | 1 | Load result broadcast |
| cdb_tag | output | TAGW | Reorder tag of the broadcast load |
| cdb_value | output | XLEN | Loaded value |

## Verification
On every cycle the assertions check that the read grant is at most one-hot and that allocation never lands on an occupied entry. They also check that a full buffer refuses loads, that a broadcast always answers the read of the previous cycle, and that a flush both silences the memory and result ports and empties the buffer. The bench's scenarios are what demonstrate the address arithmetic, including negative offsets and wrap-around. They also show the wake-up timing when the base tag is seen in the issue cycle itself or later, and the ordering where a younger ready load passes an older waiting one. Dropping a load offered to a full buffer, and ignoring a stray response to a free entry, are likewise shown only by the scenarios.

// File: rtl/lb_pkg.sv
package lb_pkg;
  typedef enum logic [2:0] {
    PH_FREE  = 3'd0,
    PH_WBASE = 3'd1,
    PH_AGEN  = 3'd2,
    PH_MEMQ  = 3'd3,
    PH_INFL  = 3'd4
  } lb_phase_e;
endpackage

// File: rtl/lb_alloc.sv
module lb_alloc #(
  parameter int NENT = 3
) (
  input  logic [NENT-1:0] free_vec,
  output logic [NENT-1:0] pick_vec
);
  always_comb begin
    logic found;
    found    = 1'b0;
    pick_vec = '0;
    for (int i = 0; i < NENT; i++) begin
      if (free_vec[i] && !found) begin
        pick_vec[i] = 1'b1;
        found       = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lb_age.sv
module lb_age #(
  parameter int NENT = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NENT-1:0] alloc_vec,
  input  logic [NENT-1:0] req_vec,
  output logic [NENT-1:0] grant_vec
);
  // older_q[j][i] = 1 : entry j was allocated before entry i
  logic [NENT-1:0][NENT-1:0] older_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      older_q <= '0;
    end else begin
      for (int i = 0; i < NENT; i++) begin
        if (alloc_vec[i]) begin
          for (int j = 0; j < NENT; j++) begin
            older_q[i][j] <= 1'b0;
            if (j != i) older_q[j][i] <= 1'b1;
          end
        end
      end
    end
  end

  generate
    for (genvar g = 0; g < NENT; g++) begin : g_sel
      logic [NENT-1:0] col;
      for (genvar h = 0; h < NENT; h++) begin : g_col
        assign col[h] = older_q[h][g];
      end
      assign grant_vec[g] = req_vec[g] && ((req_vec & col) == '0);
    end
  endgenerate
endmodule

// File: rtl/lb_entry.sv
module lb_entry
  import lb_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int OFFW = 16,
  parameter int TAGW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            alloc,
  input  logic [TAGW-1:0] iss_rob,
  input  logic [XLEN-1:0] iss_base,
  input  logic            iss_base_rdy,
  input  logic [TAGW-1:0] iss_base_tag,
  input  logic [OFFW-1:0] iss_off,
  input  logic            rb_valid,
  input  logic [TAGW-1:0] rb_tag,
  input  logic [XLEN-1:0] rb_value,
  input  logic            grant,
  input  logic            resp_done,
  output lb_phase_e       phase,
  output logic [TAGW-1:0] rob_tag,
  output logic [XLEN-1:0] eff_addr
);
  logic [XLEN-1:0] base_q;
  logic [OFFW-1:0] off_q;
  logic [TAGW-1:0] wait_tag_q;

  function automatic logic [XLEN-1:0] ea_calc(input logic [XLEN-1:0] b,
                                              input logic [OFFW-1:0] o);
    return b + XLEN'($signed(o));
  endfunction

  wire issue_hit = rb_valid && (rb_tag == iss_base_tag);
  wire wait_hit  = rb_valid && (rb_tag == wait_tag_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= PH_FREE;
      rob_tag    <= '0;
      eff_addr   <= '0;
      base_q     <= '0;
      off_q      <= '0;
      wait_tag_q <= '0;
    end else if (flush) begin
      phase <= PH_FREE;
    end else begin
      unique case (phase)
        PH_FREE: if (alloc) begin
          rob_tag    <= iss_rob;
          off_q      <= iss_off;
          wait_tag_q <= iss_base_tag;
          if (iss_base_rdy) begin
            base_q <= iss_base;
            phase  <= PH_AGEN;
          end else if (issue_hit) begin
            base_q <= rb_value;
            phase  <= PH_AGEN;
          end else begin
            phase  <= PH_WBASE;
          end
        end
        PH_WBASE: if (wait_hit) begin
          base_q <= rb_value;
          phase  <= PH_AGEN;
        end
        PH_AGEN: begin
          eff_addr <= ea_calc(base_q, off_q);
          phase    <= PH_MEMQ;
        end
        PH_MEMQ: if (grant) phase <= PH_INFL;
        PH_INFL: if (resp_done) phase <= PH_FREE;
        default: phase <= PH_FREE;
      endcase
    end
  end
endmodule

// File: rtl/load_buffer.sv
module load_buffer
  import lb_pkg::*;
#(
  parameter int NENT = 3,
  parameter int XLEN = 32,
  parameter int OFFW = 16,
  parameter int TAGW = 4,
  localparam int IDW = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            iss_valid,
  input  logic [TAGW-1:0] iss_rob,
  input  logic [XLEN-1:0] iss_base,
  input  logic            iss_base_rdy,
  input  logic [TAGW-1:0] iss_base_tag,
  input  logic [OFFW-1:0] iss_off,
  output logic            iss_ready,
  input  logic            rb_valid,
  input  logic [TAGW-1:0] rb_tag,
  input  logic [XLEN-1:0] rb_value,
  output logic            mrd_valid,
  output logic [IDW-1:0]  mrd_id,
  output logic [XLEN-1:0] mrd_addr,
  input  logic            mresp_valid,
  input  logic [IDW-1:0]  mresp_id,
  input  logic [XLEN-1:0] mresp_data,
  output logic            cdb_valid,
  output logic [TAGW-1:0] cdb_tag,
  output logic [XLEN-1:0] cdb_value
);
  // named internal events (observed by the checker)
  logic [NENT-1:0] busy_vec;
  logic [NENT-1:0] free_vec;
  logic [NENT-1:0] pick_vec;
  logic [NENT-1:0] alloc_vec;
  logic [NENT-1:0] req_vec;
  logic [NENT-1:0] grant_vec;
  logic [NENT-1:0] resp_hit_vec;

  lb_phase_e       phase_arr [NENT];
  logic [TAGW-1:0] tag_arr   [NENT];
  logic [XLEN-1:0] addr_arr  [NENT];

  assign free_vec  = ~busy_vec;
  assign iss_ready = (|free_vec) && !flush;
  assign alloc_vec = pick_vec & {NENT{iss_valid && iss_ready}};

  lb_alloc #(.NENT(NENT)) u_alloc (
    .free_vec (free_vec),
    .pick_vec (pick_vec)
  );

  lb_age #(.NENT(NENT)) u_age (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_vec (alloc_vec),
    .req_vec   (req_vec),
    .grant_vec (grant_vec)
  );

  generate
    for (genvar g = 0; g < NENT; g++) begin : g_ent
      assign busy_vec[g]     = (phase_arr[g] != PH_FREE);
      assign req_vec[g]      = (phase_arr[g] == PH_MEMQ) && !flush;
      assign resp_hit_vec[g] = mresp_valid && !flush &&
                               (mresp_id == IDW'(g)) &&
                               (phase_arr[g] == PH_INFL);
      lb_entry #(.XLEN(XLEN), .OFFW(OFFW), .TAGW(TAGW)) u_ent (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush        (flush),
        .alloc        (alloc_vec[g]),
        .iss_rob      (iss_rob),
        .iss_base     (iss_base),
        .iss_base_rdy (iss_base_rdy),
        .iss_base_tag (iss_base_tag),
        .iss_off      (iss_off),
        .rb_valid     (rb_valid),
        .rb_tag       (rb_tag),
        .rb_value     (rb_value),
        .grant        (grant_vec[g]),
        .resp_done    (resp_hit_vec[g]),
        .phase        (phase_arr[g]),
        .rob_tag      (tag_arr[g]),
        .eff_addr     (addr_arr[g])
      );
    end
  endgenerate

  always_comb begin
    mrd_id   = '0;
    mrd_addr = '0;
    cdb_tag  = '0;
    for (int i = 0; i < NENT; i++) begin
      if (grant_vec[i]) begin
        mrd_id   = IDW'(i);
        mrd_addr = addr_arr[i];
      end
      if (resp_hit_vec[i]) cdb_tag = tag_arr[i];
    end
  end

  assign mrd_valid = |grant_vec;
  assign cdb_valid = |resp_hit_vec;
  assign cdb_value = mresp_data;
endmodule

// File: rtl/lb_chk.sv
module lb_chk #(
  parameter int NENT = 3,
  parameter int IDW  = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            flush,
  input logic            iss_ready,
  input logic            mrd_valid,
  input logic [IDW-1:0]  mrd_id,
  input logic            mresp_id_ok,
  input logic [IDW-1:0]  mresp_id,
  input logic            cdb_valid,
  input logic [NENT-1:0] busy_vec,
  input logic [NENT-1:0] alloc_vec,
  input logic [NENT-1:0] grant_vec
);
  // R5
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));

  // R2
  alloc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alloc_vec) && ((alloc_vec & busy_vec) == '0));

  // R2
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&busy_vec) |-> !iss_ready);

  // R6
  cdb_answers_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cdb_valid |-> ($past(mrd_valid) && mresp_id_ok && (mresp_id == $past(mrd_id))));

  // R7
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!mrd_valid && !cdb_valid && !iss_ready));

  // R7
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (busy_vec == '0));
endmodule

bind load_buffer lb_chk #(.NENT(NENT), .IDW(IDW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush       (flush),
  .iss_ready   (iss_ready),
  .mrd_valid   (mrd_valid),
  .mrd_id      (mrd_id),
  .mresp_id_ok (mresp_valid),
  .mresp_id    (mresp_id),
  .cdb_valid   (cdb_valid),
  .busy_vec    (busy_vec),
  .alloc_vec   (alloc_vec),
  .grant_vec   (grant_vec)
);

// File: tb/load_buffer_test.sv
`timescale 1ns/1ps
module load_buffer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        iss_valid = 1'b0;
  logic [3:0]  iss_rob = '0;
  logic [31:0] iss_base = '0;
  logic        iss_base_rdy = 1'b0;
  logic [3:0]  iss_base_tag = '0;
  logic [15:0] iss_off = '0;
  logic        iss_ready;
  logic        rb_valid = 1'b0;
  logic [3:0]  rb_tag = '0;
  logic [31:0] rb_value = '0;
  logic        mrd_valid;
  logic [1:0]  mrd_id;
  logic [31:0] mrd_addr;
  logic        mresp_valid = 1'b0;
  logic [1:0]  mresp_id = '0;
  logic [31:0] mresp_data = '0;
  logic        cdb_valid;
  logic [3:0]  cdb_tag;
  logic [31:0] cdb_value;

  always #10 clk = ~clk;

  load_buffer uut (.*);

  int total = 0;
  int bad = 0;
  int cyc = 0;
  string cur_req = "R1";

  // staged stimulus for the next step
  bit s_flush, s_iss, s_rdy, s_rb;
  int s_rob, s_btag, s_rbtag;
  logic [31:0] s_base, s_rbval;
  logic [15:0] s_off;
  bit inj_v; int inj_id; logic [31:0] inj_data;
  bit nx_mv; logic [1:0] nx_mid; logic [31:0] nx_md;

  typedef struct {
    int tag; int slot; bit known; int btag;
    logic [15:0] off; logic [31:0] addr; int rdy; bit infl;
  } rec_t;
  rec_t q[$];
  bit busy[3];
  bit pend_v; int pend_slot; int pend_tag; logic [31:0] pend_data;

  function automatic logic [31:0] ref_ea(logic [31:0] b, logic [15:0] o);
    longint t;
    t = longint'(b) + (o[15] ? (longint'(o) - 65536) : longint'(o));
    return t[31:0];
  endfunction

  function automatic logic [31:0] memf(logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h0000_3C3C;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic issue(int rob, logic [31:0] base, bit rdy, int btag, logic [15:0] off);
    s_iss = 1; s_rob = rob; s_base = base; s_rdy = rdy; s_btag = btag; s_off = off;
  endtask

  task automatic bus(int tag, logic [31:0] val);
    s_rb = 1; s_rbtag = tag; s_rbval = val;
  endtask

  task automatic step();
    int k; bit e_ready; bit e_cv; int slot;
    bit np_v; int np_slot; int np_tag; logic [31:0] np_data;
    @(negedge clk);
    flush = s_flush; iss_valid = s_iss; iss_rob = 4'(s_rob); iss_base = s_base;
    iss_base_rdy = s_rdy; iss_base_tag = 4'(s_btag); iss_off = s_off;
    rb_valid = s_rb; rb_tag = 4'(s_rbtag); rb_value = s_rbval;
    mresp_valid = nx_mv; mresp_id = nx_mid; mresp_data = nx_md;
    #1;
    e_ready = !s_flush && !(busy[0] && busy[1] && busy[2]);
    chk(iss_ready === e_ready, cur_req, "iss_ready", iss_ready, e_ready);
    k = -1;
    if (!s_flush)
      foreach (q[i]) if (k < 0 && q[i].known && !q[i].infl && q[i].rdy <= cyc) k = i;
    chk(mrd_valid === (k >= 0), cur_req, "mrd_valid", mrd_valid, k >= 0);
    if (k >= 0 && mrd_valid === 1'b1) begin
      chk(mrd_addr === q[k].addr, cur_req, "mrd_addr", mrd_addr, q[k].addr);
      chk(mrd_id === 2'(q[k].slot), cur_req, "mrd_id", mrd_id, q[k].slot);
    end
    e_cv = pend_v && !s_flush;
    chk(cdb_valid === e_cv, cur_req, "cdb_valid", cdb_valid, e_cv);
    if (e_cv && cdb_valid === 1'b1) begin
      chk(cdb_tag === 4'(pend_tag), cur_req, "cdb_tag", cdb_tag, pend_tag);
      chk(cdb_value === pend_data, cur_req, "cdb_value", cdb_value, pend_data);
    end
    // memory model: one-cycle registered read
    nx_mv = mrd_valid; nx_mid = mrd_id; nx_md = memf(mrd_addr);
    if (inj_v) begin nx_mv = 1; nx_mid = 2'(inj_id); nx_md = inj_data; end
    // reference model update
    if (s_flush) begin
      q.delete(); busy = '{0, 0, 0}; pend_v = 0;
    end else begin
      foreach (q[i])
        if (!q[i].known && s_rb && q[i].btag == s_rbtag) begin
          q[i].known = 1; q[i].addr = ref_ea(s_rbval, q[i].off); q[i].rdy = cyc + 2;
        end
      np_v = 0; np_slot = 0; np_tag = 0; np_data = '0;
      if (k >= 0) begin
        q[k].infl = 1; np_v = 1; np_slot = q[k].slot; np_tag = q[k].tag;
        np_data = memf(q[k].addr);
      end
      slot = -1;
      if (s_iss && e_ready)
        for (int i = 2; i >= 0; i--) if (!busy[i]) slot = i;
      if (pend_v) begin
        for (int i = 0; i < q.size(); i++)
          if (q[i].infl && q[i].slot == pend_slot) begin q.delete(i); break; end
        busy[pend_slot] = 0;
      end
      if (slot >= 0) begin
        rec_t r;
        r.tag = s_rob; r.slot = slot; r.btag = s_btag; r.off = s_off; r.infl = 0;
        r.known = 0; r.addr = '0; r.rdy = 0;
        if (s_rdy) begin r.known = 1; r.addr = ref_ea(s_base, s_off); r.rdy = cyc + 2; end
        else if (s_rb && s_rbtag == s_btag) begin
          r.known = 1; r.addr = ref_ea(s_rbval, s_off); r.rdy = cyc + 2;
        end
        busy[slot] = 1; q.push_back(r);
      end
      pend_v = np_v; pend_slot = np_slot; pend_tag = np_tag; pend_data = np_data;
    end
    s_flush = 0; s_iss = 0; s_rb = 0; inj_v = 0;
    cyc++;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  bit finished = 0;
  initial begin
    #3000000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(iss_ready === 1'b1, "R1", "iss_ready", iss_ready, 1);
    chk(mrd_valid === 1'b0, "R1", "mrd_valid", mrd_valid, 0);
    chk(cdb_valid === 1'b0, "R1", "cdb_valid", cdb_valid, 0);

    // R3 base ready, zero / negative / wrapping offsets
    cur_req = "R3";
    issue(1, 32'd100, 1, 0, 16'd0); run(5);
    issue(2, 32'h10, 1, 0, 16'hFFFC); run(5);
    issue(3, 32'h2, 1, 0, 16'hFFF8); issue(3, 32'h2, 1, 0, 16'hFFF8); run(1);
    issue(4, 32'hFFFF_FFF0, 1, 0, 16'h0020); run(6);

    // R4 base pending: later wake-up, and wake-up in the issue cycle
    cur_req = "R4";
    issue(5, 32'hDEAD, 0, 5, 16'd8); run(4);
    bus(7, 32'h111); run(1);
    bus(5, 32'd200); run(6);
    issue(6, 32'h0, 0, 6, 16'd4); bus(6, 32'd300); run(6);

    // R2 fill all entries, offer a fourth while full; R5 drain order
    cur_req = "R2";
    issue(7, 0, 0, 9, 16'd0); run(1);
    issue(8, 0, 0, 9, 16'd4); run(1);
    issue(9, 0, 0, 9, 16'd8); run(1);
    issue(10, 32'h55, 1, 0, 16'd0); run(2);
    cur_req = "R5";
    bus(9, 32'h1000); run(8);

    // R5 younger ready load passes an older waiting load
    issue(11, 0, 0, 11, 16'd2); run(1);
    issue(12, 32'h400, 1, 0, 16'd1); run(1);
    issue(13, 32'h800, 1, 0, 16'd3); run(1);
    bus(11, 32'h300); run(8);

    // R7 flush in the response cycle, with another entry waiting
    cur_req = "R7";
    issue(14, 0, 0, 3, 16'd0); run(1);
    issue(15, 32'h900, 1, 0, 16'd0); run(3);
    s_flush = 1; run(1);
    bus(3, 32'h77); run(4);
    issue(1, 32'hA00, 1, 0, 16'd6); run(1);
    s_flush = 1; issue(2, 32'hB00, 1, 0, 16'd0); run(1);
    run(4);

    // R6 stray response to a free entry produces no broadcast
    cur_req = "R6";
    inj_v = 1; inj_id = 1; inj_data = 32'hBAD0_BAD0; run(3);
    issue(3, 32'h40, 1, 0, 16'h10); run(6);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule